// File: doc/BRIEF.md
# Cyclic Counter Target Seeker

This block steers an external free-running cyclic counter until the counter's output equals a requested draw value. That output selects the component values for an experiment. A one-cycle start pulse arrives with a draw value of `W` bits (0 to 3 at the default width). The block captures the draw value and compares it with the counter's present output. If the two already agree, the block finishes at once and never lets the counter move. If they differ, the block raises a run enable. The counter then advances, and the block compares again each time the counter reports a cycle through its tick input. The run enable falls in the same cycle as the matching tick.

A done flag reports that the counter holds the requested value. The flag stays up until the next accepted start. A start that arrives while a search is under way is dropped.

Top module: `draw_seeker`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `run_o` and `done_o` are both 0.
- R2: A start accepted while `target_i` differs from `count_i` makes `run_o` 1 and `done_o` 0 from the next cycle.
- R3: A start accepted while `target_i` equals `count_i` leaves `run_o` at 0 and makes `done_o` 1 from the next cycle.
- R4: During a search, the block compares only in cycles where `tick_i` is 1. A match on `count_i` without a tick leaves `run_o` at 1.
- R5: In a cycle with `tick_i` at 1 and `count_i` equal to the captured target, `run_o` is 0 in that same cycle and `done_o` is 1 from the next cycle.
- R6: Once `done_o` is 1, it stays 1 and `run_o` stays 0 until a start is accepted.
- R7: The target is captured on the accepted start. Changes on `target_i` during a search have no effect on when the search ends.
- R8: A start while `run_o` is 1 is ignored: neither the target nor the search changes.
- R9: A start received while `done_o` is 1 is accepted and behaves as in R2 or R3. On a mismatch this clears `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse carrying a new draw value |
| target_i | input | W | Requested draw value |
| count_i | input | W | Current output of the external counter |
| tick_i | input | 1 | One pulse per counter cycle |
| run_o | output | 1 | Run enable to the external counter |
| done_o | output | 1 | Counter holds the requested value |

## Verification
The bench checks a start that finds an immediate match. A design that got this wrong would pulse the run enable for one cycle. It checks a count that matches the target without a tick. A design that compared on every cycle would stop the counter there. It moves `target_i` and pulses start in the middle of a search. A design that did not capture the target, or that accepted the second start, would stop at the wrong value. It also restarts from the done state with a mismatch. A design that left done set would report a false finish. After the directed cases, a long random phase compares both outputs against a behavioural model on every cycle.

// File: rtl/draw_seeker.sv
module draw_seeker #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] target_i,
  input  logic [W-1:0] count_i,
  input  logic         tick_i,
  output logic         run_o,
  output logic         done_o
);

  typedef enum logic [1:0] {S_IDLE, S_SEEK, S_DONE} state_t;

  state_t       st;
  logic [W-1:0] tgt_q;
  logic         busy, hit, accept, now_eq;

  assign busy   = (st == S_SEEK);
  assign hit    = busy & tick_i & (count_i == tgt_q);
  assign accept = start_i & ~busy;
  assign now_eq = (count_i == target_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tgt_q <= '0;
    end else if (accept) begin
      tgt_q <= target_i;
      st    <= now_eq ? S_DONE : S_SEEK;
    end else if (hit) begin
      st <= S_DONE;
    end
  end

  assign run_o  = busy & ~hit;
  assign done_o = (st == S_DONE);

  AST_START_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !now_eq) |=> (busy && !done_o)); // R2
  AST_START_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && now_eq) |=> (done_o && !run_o)); // R3
  AST_TICK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick_i && count_i == tgt_q) |=> done_o); // R5
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && !run_o)); // R6
  AST_TGT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tgt_q)); // R7
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tick_i && count_i == tgt_q)) |=> busy); // R8
  AST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_o && done_o)); // R6

endmodule

// File: tb/draw_seeker_test.sv
module draw_seeker_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 2;

  logic clk = 0, rst_n = 0, start_i = 0, tick_i = 0;
  logic [W-1:0] target_i = '0, count_i = '0;
  logic run_o, done_o;
  int errors = 0, checks = 0;
  int ms = 0, mt = 0;
  bit finished = 0;

  draw_seeker #(.W(W)) uut (.clk(clk), .rst_n(rst_n), .start_i(start_i),
    .target_i(target_i), .count_i(count_i), .tick_i(tick_i),
    .run_o(run_o), .done_o(done_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input bit s, input int t, input int c, input bit k);
    @(negedge clk);
    start_i = s; target_i = W'(t); count_i = W'(c); tick_i = k;
    #1;
    chk(tag, "run_o", run_o, (ms == 1) && !(k && c == mt));
    chk(tag, "done_o", done_o, ms == 2);
    if (s && ms != 1) begin
      mt = t;
      ms = (c == t) ? 2 : 1;
    end else if (ms == 1 && k && c == mt) begin
      ms = 2;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "run_o", run_o, 1'b0);
    chk("R1", "done_o", done_o, 1'b0);
    @(negedge clk);
    rst_n = 1;
    step("R1", 0, 0, 0, 0);
    step("R2", 1, 2, 0, 0);
    step("R2", 0, 2, 1, 1);
    step("R4", 0, 2, 2, 0);
    step("R7", 0, 0, 0, 1);
    step("R8", 1, 1, 1, 1);
    step("R8", 0, 1, 1, 1);
    step("R5", 0, 1, 2, 1);
    step("R5", 0, 0, 3, 0);
    step("R6", 0, 0, 1, 1);
    step("R6", 0, 3, 2, 1);
    step("R3", 1, 3, 3, 0);
    step("R3", 0, 0, 0, 1);
    step("R9", 1, 1, 0, 0);
    step("R9", 0, 1, 0, 1);
    step("R5", 0, 1, 1, 1);
    step("R6", 0, 1, 1, 0);
    rst_n = 0;
    ms = 0;
    step("R1", 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 2000; i++) begin
      step("R9", ($urandom % 5) == 0, $urandom % 4, $urandom % 4, $urandom % 2);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule